// File: doc/BRIEF.md
# Accumulate-and-Wait Loop Controller

This block runs a repeat-until loop in hardware. A start pulse loads an initial operand into an accumulator. The block then adds a second operand to it once per clock until the running value is strictly greater than a threshold. The frozen result feeds a downstream adder, which produces `x = acc + d`.

Before it reports completion, the controller gives that adder time to settle. It loads a down-counter with a wait count N and counts it down to zero, which takes N+1 cycles. Only then does it raise `done_o`. The result stays held until the next start pulse.

Threshold, wait count and data width are parameters, with defaults of 100, 4 and 16 bits.

Top module: `accw_top`

## Requirements
- R1: After reset `done_o` is 0 and the accumulator is 0, so `x_o` equals `d_i`.
- R2: A `start_i` high on a clock edge while the block is idle or done loads `a_init_i` into the accumulator. That same edge clears `done_o`.
- R3: While looping with accumulator <= THRESH, each clock adds `b_i` to the accumulator as an unsigned sum that saturates at 2^WIDTH-1 instead of wrapping.
- R4: The loop exits on the first evaluation where the accumulator is strictly greater than THRESH. From then on the accumulator no longer changes.
- R5: On exit the down-counter is loaded with WAIT_N and then decrements once per clock, so the wait lasts WAIT_N+1 cycles. Counting the start edge as edge 0, `done_o` first reads 1 after edge k+WAIT_N+2, where k is the number of additions.
- R6: If `a_init_i` already exceeds THRESH, no addition is made (k=0) and the block goes straight to the wait after one evaluation.
- R7: `x_o` equals (accumulator + `d_i`) mod 2^WIDTH at all times. It follows `d_i` combinationally.
- R8: `done_o` and the accumulator hold their values until the next accepted start.
- R9: A `start_i` pulse while looping or waiting is ignored. Neither the result nor the completion cycle changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request |
| a_init_i | input | WIDTH | Initial accumulator value |
| b_i | input | WIDTH | Increment added per iteration |
| d_i | input | WIDTH | Offset for the output adder |
| x_o | output | WIDTH | Accumulator plus `d_i` |
| done_o | output | 1 | Completion flag |

## Verification
The checker assumes that `a_init_i` only matters on an accepted start edge. It also assumes the loop can terminate: either `b_i` is nonzero, or the initial value already exceeds THRESH, and THRESH stays below 2^WIDTH-1. The directed stimulus always drives a nonzero `b_i`, so saturation can only end a loop by crossing the threshold. It drives `d_i` freely, because the checker's hold properties are stated on the accumulator rather than on `x_o`.

// File: rtl/accw_pkg.sv
package accw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOP = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } accw_state_e;
endpackage

// File: rtl/accw_accum.sv
module accw_accum #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned THRESH = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_init_i,
  input  logic [WIDTH-1:0] a_init_i,
  input  logic             ld_acc_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] acc_o,
  output logic             over_o
);
  localparam logic [WIDTH-1:0] THR_W = WIDTH'(THRESH);

  logic [WIDTH:0]   sum_ext;
  logic [WIDTH-1:0] sum_sat;

  assign sum_ext = {1'b0, acc_o} + {1'b0, b_i};
  // saturate instead of wrapping so the threshold test cannot be skipped
  assign sum_sat = sum_ext[WIDTH] ? {WIDTH{1'b1}} : sum_ext[WIDTH-1:0];
  assign over_o  = acc_o > THR_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          acc_o <= '0;
    else if (load_init_i) acc_o <= a_init_i;
    else if (ld_acc_i)    acc_o <= sum_sat;
  end
endmodule

// File: rtl/accw_cnt.sv
module accw_cnt #(
  parameter int unsigned WAIT_N = 4,
  localparam int unsigned CW    = (WAIT_N < 1) ? 1 : $clog2(WAIT_N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic          dn_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o
);
  assign zero_o = (cnt_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_o <= '0;
    else if (ld_i)            cnt_o <= CW'(WAIT_N);
    else if (dn_i && !zero_o) cnt_o <= cnt_o - 1'b1;
  end
endmodule

// File: rtl/accw_fsm.sv
module accw_fsm
  import accw_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        over_i,
  input  logic        cnt_zero_i,
  output accw_state_e state_o,
  output logic        load_init_o,
  output logic        ld_acc_o,
  output logic        ld_cnt_o,
  output logic        cnt_dn_o,
  output logic        done_o
);
  accw_state_e state_d;

  always_comb begin
    load_init_o = 1'b0;
    ld_acc_o    = 1'b0;
    ld_cnt_o    = 1'b0;
    cnt_dn_o    = 1'b0;
    state_d     = state_o;
    unique case (state_o)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          load_init_o = 1'b1;
          state_d     = ST_LOOP;
        end
      end
      ST_LOOP: begin
        if (over_i) begin
          ld_cnt_o = 1'b1;
          state_d  = ST_WAIT;
        end else begin
          ld_acc_o = 1'b1;
        end
      end
      ST_WAIT: begin
        cnt_dn_o = 1'b1;
        if (cnt_zero_i) state_d = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= ST_IDLE;
    else         state_o <= state_d;
  end

  assign done_o = (state_o == ST_DONE);
endmodule

// File: rtl/accw_top.sv
module accw_top
  import accw_pkg::*;
#(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned THRESH = 100,
  parameter int unsigned WAIT_N = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] a_init_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] x_o,
  output logic             done_o
);
  localparam int unsigned CW = (WAIT_N < 1) ? 1 : $clog2(WAIT_N + 1);

  accw_state_e      state;
  logic             load_init, ld_acc, ld_cnt, cnt_dn, over, cnt_zero;
  logic [WIDTH-1:0] acc;
  logic [CW-1:0]    cnt;

  accw_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .over_i     (over),
    .cnt_zero_i (cnt_zero),
    .state_o    (state),
    .load_init_o(load_init),
    .ld_acc_o   (ld_acc),
    .ld_cnt_o   (ld_cnt),
    .cnt_dn_o   (cnt_dn),
    .done_o     (done_o)
  );

  accw_accum #(.WIDTH(WIDTH), .THRESH(THRESH)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_init_i(load_init),
    .a_init_i   (a_init_i),
    .ld_acc_i   (ld_acc),
    .b_i        (b_i),
    .acc_o      (acc),
    .over_o     (over)
  );

  accw_cnt #(.WAIT_N(WAIT_N)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (ld_cnt),
    .dn_i  (cnt_dn),
    .cnt_o (cnt),
    .zero_o(cnt_zero)
  );

  // downstream function, given WAIT_N+1 cycles to settle
  assign x_o = acc + d_i;
endmodule

// File: rtl/accw_chk.sv
module accw_chk
  import accw_pkg::*;
#(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned THRESH = 100,
  parameter int unsigned WAIT_N = 4,
  parameter int unsigned CW     = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [WIDTH-1:0] a_init_i,
  input accw_state_e      state,
  input logic [WIDTH-1:0] acc,
  input logic [CW-1:0]    cnt,
  input logic             done_o
);
  localparam logic [WIDTH-1:0] THR_W = WIDTH'(THRESH);

  assert_init_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (state == ST_IDLE || state == ST_DONE)) |=> (acc == $past(a_init_i) && !done_o));

  assert_acc_grow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_LOOP && acc <= THR_W) |=> (acc >= $past(acc)));

  assert_exit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_LOOP && acc > THR_W) |=> (state == ST_WAIT && cnt == CW'(WAIT_N)));

  assert_freeze_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WAIT) |=> $stable(acc));

  assert_cnt_dec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WAIT && cnt != '0) |=> (state == ST_WAIT && cnt == $past(cnt) - 1'b1));

  assert_done_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(acc)));

  assert_busy_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WAIT && start_i) |=> (state == ST_WAIT || state == ST_DONE));
endmodule

bind accw_top accw_chk #(.WIDTH(WIDTH), .THRESH(THRESH), .WAIT_N(WAIT_N), .CW(CW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .a_init_i(a_init_i),
  .state   (state),
  .acc     (acc),
  .cnt     (cnt),
  .done_o  (done_o)
);

// File: tb/sim_accw_top.sv
module sim_accw_top;
  localparam int unsigned W   = 16;
  localparam int unsigned THR = 100;
  localparam int unsigned N   = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] a_init = '0, b = '0, d = '0;
  logic [W-1:0] x;
  logic         done;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  accw_top #(.WIDTH(W), .THRESH(THR), .WAIT_N(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .a_init_i(a_init), .b_i(b), .d_i(d), .x_o(x), .done_o(done)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model: additions and final accumulator
  task automatic model(input logic [W-1:0] ai, input logic [W-1:0] bi,
                       output int k, output logic [W-1:0] fin);
    longint a;
    a = ai;
    k = 0;
    while (a <= THR) begin
      a = a + bi;
      if (a > (2**W) - 1) a = (2**W) - 1;
      k++;
    end
    fin = W'(a);
  endtask

  task automatic run(input string tag, input logic [W-1:0] ai, input logic [W-1:0] bi,
                     input logic [W-1:0] di, input bit poke);
    int k, e;
    logic [W-1:0] fin;
    model(ai, bi, k, fin);
    a_init = ai; b = bi; d = di;
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    chk({tag, " R2 done cleared on start"}, done, 0);
    e = 0;
    while (!done && e < 2000) begin
      @(posedge clk); e++;
      if (poke && e == 2) begin
        @(negedge clk); start = 1'b1; a_init = 16'd999;
        @(posedge clk); e++;
        @(negedge clk); start = 1'b0; a_init = ai;
      end else begin
        @(negedge clk);
      end
    end
    chk({tag, " R5 done edge"}, e, k + N + 2);
    chk({tag, " R7 x value"}, x, W'(fin + di));
    repeat (3) @(negedge clk);
    chk({tag, " R8 done held"}, done, 1);
    chk({tag, " R8 x held"}, x, W'(fin + di));
  endtask

  task automatic t_reset();
    d = 16'd77;
    #1;
    chk("R1 done at reset", done, 0);
    chk("R1 x at reset", x, 77);
  endtask

  task automatic t_basic();       run("R3 basic", 16'd0, 16'd7, 16'd3, 1'b0); endtask
  task automatic t_boundary();    run("R4 equal-threshold", 16'd93, 16'd7, 16'd1, 1'b0); endtask
  task automatic t_big_init();    run("R6 init over", 16'd500, 16'd9, 16'd2, 1'b0); endtask
  task automatic t_saturate();    run("R3 saturate", 16'd50, 16'hFFFF, 16'd0, 1'b0); endtask
  task automatic t_busy();        run("R9 busy start", 16'd10, 16'd20, 16'd5, 1'b1); endtask

  task automatic t_x_follows_d();
    @(negedge clk); d = 16'd1000;
    #1;
    chk("R7 x follows d", x, W'(16'hFFFF + 16'd1000));
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_basic();
    t_boundary();
    t_big_init();
    t_saturate();
    t_x_follows_d();
    t_busy();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule